// File: doc/BRIEF.md
# Delayed Transaction Discard Controller

This block sits on the request path of a bus target and manages a single slot for a delayed transaction. A delayed-mode request is a memory read, an I/O read or an I/O write that arrives while delayed mode is on. When the slot is empty, the block captures the address and command of that request and answers with retry. The requester must come back with the same address and command. The local application signals that completion data exists, and the next matching request then finishes normally and empties the slot.

A 15-bit discard timer starts when the request is captured. If the requester has not collected the result when the timer reaches all ones, the slot is emptied and the application sees a one-cycle low pulse on an expiry output. Three application controls decide how requests are answered: abort, forced retry and delayed-mode enable. Each control passes through a hold filter, so it takes effect only after it has been stable for two cycles. The delayed-mode setting is held fixed while the slot is occupied.

An asynchronous FIFO clear empties the slot and holds a local-ready output low, but it leaves the response path running. The ready output also stays low during reset and for 16 cycles after reset or clear ends.

Top module: `dly_txn_ctrl`

## Requirements
- R1: While `rst` is high, at each clock edge `resp_valid` goes to 0, `expire_n` goes to 1, `slot_busy` goes to 0 and `local_ready` goes to 0.
- R2: Each request presented with `req_valid` at a clock edge produces `resp_valid`=1 after that same edge, with `resp_code` encoded as 0 = done, 1 = retry, 2 = abort.
- R3: Only command codes 4'b0110 (memory read), 4'b0010 (I/O read) and 4'b0011 (I/O write) take the delayed path. Any other command is answered done and leaves the slot and its completion flag unchanged.
- R4: With delayed mode on and the slot empty, a delayed-path request is answered retry, and `slot_busy` is 1 after that edge.
- R5: While the slot is occupied, a delayed-path request with the same address and command is answered done and empties the slot, but only if a `cpl_ready` pulse was seen at an earlier edge. Otherwise that request is answered retry, and so is any request whose address or command differs.
- R6: If the slot is not emptied first, `expire_n` goes low at the 2^15-th edge after the capturing edge, and stays low for exactly one cycle. `slot_busy` falls at that same edge.
- R7: A control input takes effect at the second edge that samples its new value. A change that lasts one cycle has no effect on any response.
- R8: Filtered abort outranks filtered retry (`app_retry_n` low), and both outrank the delayed and bypass paths, for every command, configuration cycles included.
- R9: While the slot is occupied, a change on `app_delay_n` is ignored. The new setting applies only once the slot is empty.
- R10: A low `fifo_clr_n` empties the slot at once, with no expiry pulse, and forces `local_ready` low. Requests made during the clear are still answered.
- R11: `local_ready` goes high at the 16th edge after reset or clear is released, and is low before that.
- R12: A matching request that completes at the edge where the timer would expire wins: it is answered done, and no expiry pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high bus reset |
| fifo_clr_n | input | 1 | Asynchronous active-low FIFO clear |
| req_valid | input | 1 | A request is presented this cycle |
| req_cmd | input | 4 | Bus command code of the request |
| req_addr | input | AW | Address of the request |
| cpl_ready | input | 1 | Pulse: completion data for the stored request exists |
| app_delay_n | input | 1 | Active-low delayed-mode enable |
| app_retry_n | input | 1 | Active-low forced retry |
| app_abort | input | 1 | Active-high forced abort |
| resp_valid | output | 1 | Response present |
| resp_code | output | 2 | 0 done, 1 retry, 2 abort |
| slot_busy | output | 1 | A delayed request is held |
| expire_n | output | 1 | Active-low one-cycle discard pulse |
| local_ready | output | 1 | Application-side interface ready |

## Verification
The response to a request is due one edge after the request is presented. A slot change is due at that same edge. A control input becomes effective at the second edge that samples it. Expiry lands exactly 32768 edges after capture, and ready is due 16 edges after release. The bench drives inputs on falling edges and samples outputs on the falling edge that follows the edge where each result is due. Waits are counted in whole cycles from the capturing or releasing edge, so each sample lands in its due cycle or in the one just before it.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [1:0] {
    RSP_DONE  = 2'd0,
    RSP_RETRY = 2'd1,
    RSP_ABORT = 2'd2
  } rsp_e;

  localparam logic [CMD_W-1:0] CMD_IO_RD  = 4'b0010;
  localparam logic [CMD_W-1:0] CMD_IO_WR  = 4'b0011;
  localparam logic [CMD_W-1:0] CMD_MEM_RD = 4'b0110;

  function automatic logic cmd_delayable(input logic [CMD_W-1:0] c);
    return (c == CMD_IO_RD) || (c == CMD_IO_WR) || (c == CMD_MEM_RD);
  endfunction
endpackage

// File: rtl/dtc_hold_filter.sv
module dtc_hold_filter #(
  parameter int   STABLE  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  logic [STABLE-1:1] hist;
  logic              agree;

  always_comb begin
    agree = 1'b1;
    for (int i = 1; i < STABLE; i++) begin
      if (hist[i] != raw) agree = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= {(STABLE-1){RST_VAL}};
      filt <= RST_VAL;
    end else begin
      hist[1] <= raw;
      for (int i = 2; i < STABLE; i++) hist[i] <= hist[i-1];
      if (agree) filt <= raw;
    end
  end

  // R7: the filtered value only moves to a value the input already had
  p_filter_tracks_r7: assert property (@(posedge clk) disable iff (rst)
    (filt != $past(filt)) |-> ($past(raw) == filt));
endmodule

// File: rtl/dtc_discard_timer.sv
module dtc_discard_timer #(
  parameter int TW = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_n,
  input  logic run,
  input  logic flush,
  output logic hit
);
  localparam logic [TW-1:0] T_MAX = {TW{1'b1}};
  logic [TW-1:0] count;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)             count <= '0;
    else if (rst)           count <= '0;
    else if (run && !flush) count <= count + 1'b1;
    else                    count <= '0;
  end

  assign hit = run && (count == T_MAX);

  // R6: an idle slot leaves the counter at zero
  p_idle_count_zero_r6: assert property (@(posedge clk) disable iff (rst || !clr_n)
    !run |=> (count == '0));
endmodule

// File: rtl/dtc_slot.sv
module dtc_slot #(
  parameter int AW = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr_n,
  input  logic                     store,
  input  logic                     complete,
  input  logic                     timer_hit,
  input  logic                     cpl_in,
  input  logic [AW-1:0]            cur_addr,
  input  logic [dtc_pkg::CMD_W-1:0] cur_cmd,
  output logic                     busy,
  output logic                     cpl_flag,
  output logic                     match,
  output logic                     expire_n
);
  logic [AW-1:0]             held_addr;
  logic [dtc_pkg::CMD_W-1:0] held_cmd;

  assign match = busy && (held_addr == cur_addr) && (held_cmd == cur_cmd);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      busy      <= 1'b0;
      cpl_flag  <= 1'b0;
      held_addr <= '0;
      held_cmd  <= '0;
      expire_n  <= 1'b1;
    end else if (rst) begin
      busy      <= 1'b0;
      cpl_flag  <= 1'b0;
      held_addr <= '0;
      held_cmd  <= '0;
      expire_n  <= 1'b1;
    end else begin
      expire_n <= 1'b1;
      if (store) begin
        busy      <= 1'b1;
        cpl_flag  <= 1'b0;
        held_addr <= cur_addr;
        held_cmd  <= cur_cmd;
      end else if (busy && complete) begin
        busy     <= 1'b0;
        cpl_flag <= 1'b0;
      end else if (busy && timer_hit) begin
        busy     <= 1'b0;
        cpl_flag <= 1'b0;
        expire_n <= 1'b0;
      end else if (busy && cpl_in) begin
        cpl_flag <= 1'b1;
      end
    end
  end

  // R6: expiry pulse lasts one cycle
  p_expire_one_cycle_r6: assert property (@(posedge clk) disable iff (rst || !clr_n)
    !expire_n |=> expire_n);
  // R6: the slot is empty while the expiry pulse is shown
  p_expire_frees_slot_r6: assert property (@(posedge clk) disable iff (rst || !clr_n)
    !expire_n |-> !busy);
  // R5: completion flag only exists for an occupied slot
  p_cpl_needs_busy_r5: assert property (@(posedge clk) disable iff (rst || !clr_n)
    cpl_flag |-> busy);
endmodule

// File: rtl/dtc_ready_gen.sv
module dtc_ready_gen #(
  parameter int DELAY = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_n,
  output logic ready
);
  localparam int CNT_W = $clog2(DELAY + 1);
  localparam logic [CNT_W-1:0] C_END  = CNT_W'(DELAY);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(DELAY - 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (rst) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (cnt != C_END) begin
      cnt   <= cnt + 1'b1;
      ready <= (cnt == C_LAST);
    end
  end

  // R11: reset forces ready low at the following edge
  p_ready_low_r11: assert property (@(posedge clk)
    rst |=> !ready);
endmodule

// File: rtl/dly_txn_ctrl.sv
module dly_txn_ctrl #(
  parameter int AW          = 32,
  parameter int TIMER_W     = 15,
  parameter int HOLD_CYCLES = 2,
  parameter int READY_DELAY = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fifo_clr_n,
  input  logic                      req_valid,
  input  logic [dtc_pkg::CMD_W-1:0] req_cmd,
  input  logic [AW-1:0]             req_addr,
  input  logic                      cpl_ready,
  input  logic                      app_delay_n,
  input  logic                      app_retry_n,
  input  logic                      app_abort,
  output logic                      resp_valid,
  output logic [1:0]                resp_code,
  output logic                      slot_busy,
  output logic                      expire_n,
  output logic                      local_ready
);
  import dtc_pkg::*;

  logic delay_n_f, retry_n_f, abort_f;
  logic mode_held, mode_eff;
  logic busy, cpl_flag, match, timer_hit;
  logic do_store, do_complete;
  rsp_e code_d;

  dtc_hold_filter #(.STABLE(HOLD_CYCLES), .RST_VAL(1'b1)) i_flt_delay (
    .clk(clk), .rst(rst), .raw(app_delay_n), .filt(delay_n_f));
  dtc_hold_filter #(.STABLE(HOLD_CYCLES), .RST_VAL(1'b1)) i_flt_retry (
    .clk(clk), .rst(rst), .raw(app_retry_n), .filt(retry_n_f));
  dtc_hold_filter #(.STABLE(HOLD_CYCLES), .RST_VAL(1'b0)) i_flt_abort (
    .clk(clk), .rst(rst), .raw(app_abort), .filt(abort_f));

  // delayed mode is frozen while the slot is occupied
  assign mode_eff = busy ? mode_held : !delay_n_f;

  always_ff @(posedge clk) begin
    if (rst) mode_held <= 1'b0;
    else     mode_held <= mode_eff;
  end

  always_comb begin
    do_store    = 1'b0;
    do_complete = 1'b0;
    code_d      = RSP_DONE;
    if (abort_f) begin
      code_d = RSP_ABORT;
    end else if (!retry_n_f) begin
      code_d = RSP_RETRY;
    end else if (mode_eff && cmd_delayable(req_cmd)) begin
      if (!busy) begin
        do_store = req_valid;
        code_d   = RSP_RETRY;
      end else if (match && cpl_flag) begin
        do_complete = req_valid;
        code_d      = RSP_DONE;
      end else begin
        code_d = RSP_RETRY;
      end
    end
  end

  dtc_discard_timer #(.TW(TIMER_W)) i_timer (
    .clk(clk), .rst(rst), .clr_n(fifo_clr_n),
    .run(busy), .flush(do_complete), .hit(timer_hit));

  dtc_slot #(.AW(AW)) i_slot (
    .clk(clk), .rst(rst), .clr_n(fifo_clr_n),
    .store(do_store), .complete(do_complete), .timer_hit(timer_hit),
    .cpl_in(cpl_ready), .cur_addr(req_addr), .cur_cmd(req_cmd),
    .busy(busy), .cpl_flag(cpl_flag), .match(match), .expire_n(expire_n));

  dtc_ready_gen #(.DELAY(READY_DELAY)) i_ready (
    .clk(clk), .rst(rst), .clr_n(fifo_clr_n), .ready(local_ready));

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_code  <= RSP_DONE;
    end else begin
      resp_valid <= req_valid;
      resp_code  <= code_d;
    end
  end

  assign slot_busy = busy;

  // R2: every request gets a response at the next edge
  p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);
  // R8: a held abort answers every request with abort
  p_abort_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && abort_f) |=> (resp_code == RSP_ABORT));
  // R10: clear leaves no occupied slot
  p_clear_empties_r10: assert property (@(posedge clk)
    !fifo_clr_n |-> !busy);
endmodule

// File: tb/test_dly_txn_ctrl.sv
module test_dly_txn_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fifo_clr_n = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_cmd = 4'h0;
  logic [31:0] req_addr = 32'h0;
  logic        cpl_ready = 1'b0;
  logic        app_delay_n = 1'b1;
  logic        app_retry_n = 1'b1;
  logic        app_abort = 1'b0;
  logic        resp_valid;
  logic [1:0]  resp_code;
  logic        slot_busy, expire_n, local_ready;

  int n_chk = 0;
  int n_err = 0;
  int exp_lows = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dly_txn_ctrl i_dly_txn_ctrl (
    .clk(clk), .rst(rst), .fifo_clr_n(fifo_clr_n), .req_valid(req_valid),
    .req_cmd(req_cmd), .req_addr(req_addr), .cpl_ready(cpl_ready),
    .app_delay_n(app_delay_n), .app_retry_n(app_retry_n), .app_abort(app_abort),
    .resp_valid(resp_valid), .resp_code(resp_code), .slot_busy(slot_busy),
    .expire_n(expire_n), .local_ready(local_ready));

  // {cmd[3:0], addr[7:0], cpl pulse first, expected code[1:0], expected busy}
  localparam logic [15:0] VEC [12] = '{
    {4'b0111, 8'h10, 1'b0, 2'd0, 1'b0},
    {4'b1010, 8'h10, 1'b0, 2'd0, 1'b0},
    {4'b0110, 8'h10, 1'b0, 2'd1, 1'b1},
    {4'b0110, 8'h20, 1'b0, 2'd1, 1'b1},
    {4'b0010, 8'h10, 1'b0, 2'd1, 1'b1},
    {4'b0110, 8'h10, 1'b0, 2'd1, 1'b1},
    {4'b0110, 8'h10, 1'b1, 2'd0, 1'b0},
    {4'b0011, 8'h30, 1'b0, 2'd1, 1'b1},
    {4'b0011, 8'h30, 1'b1, 2'd0, 1'b0},
    {4'b0010, 8'h40, 1'b0, 2'd1, 1'b1},
    {4'b0111, 8'h40, 1'b1, 2'd0, 1'b1},
    {4'b0010, 8'h40, 1'b0, 2'd0, 1'b0}
  };

  always @(negedge clk) if (!rst && !expire_n) exp_lows++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic do_req(input logic [3:0] c, input logic [31:0] a);
    req_valid = 1'b1; req_cmd = c; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic cpl_pulse();
    cpl_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    cpl_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    cycles(3);
    chk("R1 resp_valid", resp_valid, 0);
    chk("R1 expire_n", expire_n, 1);
    chk("R1 slot_busy", slot_busy, 0);
    chk("R1 local_ready", local_ready, 0);
    rst = 1'b0;
    cycles(15);
    chk("R11 ready before 16", local_ready, 0);
    cycles(1);
    chk("R11 ready at 16", local_ready, 1);

    app_delay_n = 1'b0;
    cycles(3);
    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 12; i++) begin
      if (VEC[i][3]) cpl_pulse();
      do_req(VEC[i][15:12], {24'h0, VEC[i][11:4]});
      chk($sformatf("R2 valid v%0d", i), resp_valid, 1);
      chk($sformatf("R5 code v%0d", i), resp_code, VEC[i][2:1]);
      chk($sformatf("R4 busy v%0d", i), slot_busy, VEC[i][0]);
    end

    // R8 priority and R7 filter latency
    app_abort = 1'b1;
    do_req(4'b0111, 32'h0);
    chk("R7 abort edge1", resp_code, 0);
    do_req(4'b0111, 32'h0);
    chk("R7 abort edge2", resp_code, 0);
    do_req(4'b1011, 32'h0);
    chk("R8 abort cfg", resp_code, 2);
    app_retry_n = 1'b0;
    cycles(3);
    do_req(4'b0110, 32'h50);
    chk("R8 abort over retry", resp_code, 2);
    chk("R8 no store", slot_busy, 0);
    app_abort = 1'b0;
    cycles(3);
    do_req(4'b1011, 32'h0);
    chk("R8 retry cfg", resp_code, 1);
    app_retry_n = 1'b1;
    cycles(3);
    // R7 one-cycle pulse ignored
    app_abort = 1'b1;
    cycles(1);
    app_abort = 1'b0;
    cycles(3);
    do_req(4'b0111, 32'h0);
    chk("R7 short pulse", resp_code, 0);

    // R9 frozen mode
    do_req(4'b0110, 32'h60);
    chk("R9 stored", slot_busy, 1);
    app_delay_n = 1'b1;
    cycles(4);
    do_req(4'b0010, 32'h70);
    chk("R9 frozen retry", resp_code, 1);
    cpl_pulse();
    do_req(4'b0110, 32'h60);
    chk("R9 complete", resp_code, 0);
    chk("R9 freed", slot_busy, 0);
    do_req(4'b0110, 32'h60);
    chk("R9 mode off bypass", resp_code, 0);
    chk("R9 mode off no store", slot_busy, 0);
    app_delay_n = 1'b0;
    cycles(3);

    // R10 fifo clear
    do_req(4'b0011, 32'h80);
    chk("R10 stored", slot_busy, 1);
    #3 fifo_clr_n = 1'b0;
    #2;
    chk("R10 async empty", slot_busy, 0);
    chk("R10 ready low", local_ready, 0);
    @(negedge clk);
    do_req(4'b0111, 32'h0);
    chk("R10 answered", resp_valid, 1);
    chk("R10 answered code", resp_code, 0);
    #3 fifo_clr_n = 1'b1;
    @(negedge clk);
    cycles(14);
    chk("R11 ready after clear 15", local_ready, 0);
    cycles(1);
    chk("R11 ready after clear 16", local_ready, 1);
    chk("R10 no expiry", exp_lows, 0);

    // R6 expiry
    do_req(4'b0110, 32'h90);
    cycles(32767);
    chk("R6 before expiry", expire_n, 1);
    chk("R6 busy before", slot_busy, 1);
    cycles(1);
    chk("R6 expire low", expire_n, 0);
    chk("R6 busy falls", slot_busy, 0);
    cycles(1);
    chk("R6 one cycle", expire_n, 1);
    chk("R6 pulse count", exp_lows, 1);

    // R12 completion at the expiry edge wins
    do_req(4'b0010, 32'hA0);
    cpl_pulse();
    cycles(32766);
    do_req(4'b0010, 32'hA0);
    chk("R12 done", resp_code, 0);
    chk("R12 freed", slot_busy, 0);
    chk("R12 no pulse", expire_n, 1);
    cycles(2);
    chk("R12 pulse count", exp_lows, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule